// File: doc/BRIEF.md
# Memory-Mapped Serial Memory Controller

This block sits on a simple single-transfer bus as a slave and lets a processor read external serial flash or EEPROM parts as if they were ordinary memory. A memory-space read is turned into a serial read command on one of four banks. The device address goes out first, and the data bytes that come back are packed into an 8, 16 or 32 bit bus response. Each bank has its own select line, and each bank can choose between three-byte or two-byte addressing and between the standard read and the fast read with a dummy byte.

A small register space holds the serial clock divider and the per-bank options. It also holds a software transfer path, so firmware can send one command byte plus up to four data bytes to any bank. Write-enable and status-read commands are the typical use. The received bytes replace the bytes that were sent. When a software transfer ends, a sticky status bit is set, and the interrupt line follows that bit until firmware clears it. The bus handshake is `bus_req` held by the master until a one-cycle `bus_ready` pulse.

Address map, default parameters: bit 31 high selects the register space and bits 3:2 pick the register: 0 configuration, 1 software command, 2 software data, 3 status. With bit 31 low, bits 25:24 pick the bank and bits 23:0 form the device address.

Top module: `smem_ctrl`

## Requirements
- R1: After reset all four chip selects are high, the serial clock is low, `irq` and `bus_ready` are low, and a configuration read returns 0x00000003 (prescaler 3, all banks three-byte standard read).
- R2: A memory read drives low only the chip select whose index equals address bits 25:24. At most one chip select is ever low.
- R3: On a bank in standard mode, a memory read sends byte 0x03 and then the address, most significant byte first. In three-byte mode the address is bits 23:0.
- R4: When configuration bit 8+b is set, bank b sends only address bits 15:0 as two bytes, high byte first.
- R5: When configuration bit 12+b is set, bank b sends 0x0B, the address, and then one 0x00 dummy byte before the data bytes.
- R6: `bus_size` 0, 1 and 2 (3 acts as 2) fetch 1, 2 and 4 data bytes. The k-th received byte lands in `bus_rdata[8k+7:8k]`, and unused lanes read zero.
- R7: The serial interface uses mode 0. The clock is low whenever every chip select is high, and the data-out line never changes while the clock is high.
- R8: With prescaler value N in configuration bits 7:0, successive rising serial clock edges within a byte are 2*(N+1) system clocks apart.
- R9: The ready pulse of a memory read comes no earlier than 2*(N+1) system clocks after the chip select returns high.
- R10: A write to the software command register sends its bits 7:0 as a command to the bank in bits 9:8. Then it sends min(bits 12:10, 4) bytes from the software data register, lane 0 first. Each received byte replaces the lane it was sent from.
- R11: The end of a software transfer sets status bit 0, and `irq` follows that bit. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R12: A memory-space write is acknowledged with a ready pulse and causes no chip select activity.
- R13: A bus request that arrives during a software transfer is not acknowledged until that transfer has finished and its chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Transfer request, held until ready |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 32 | Byte address (register or memory space) |
| bus_size | input | 2 | Read size: 0 byte, 1 half, 2 or 3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 4 | Active-low chip select per bank |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench watches the serial lines through a device model and reconstructs every byte sent. It targets the header layouts: two-byte against three-byte addressing and fast against standard read. A design that mixed these up would send a wrong opcode, too many address bytes or no dummy byte, and the data lanes would then shift by one byte. It measures the rising-edge spacing at prescaler 0 and at larger values, and it measures the gap between chip select release and ready. An off-by-one divider or a missing release gap shows up as a wrong cycle count. It also checks a software transfer's write-back into the data register, the write-1-to-clear interrupt, and a request stalled behind a running software transfer. A design that acknowledged that request early would return while a chip select was still low.

// File: rtl/smem_pkg.sv
// Package: shared types and constants for the serial memory controller.
// Assumes a 32-bit bus data path; other widths are module parameters.
package smem_pkg;

    localparam int DW = 32;             // bus data width, four byte lanes
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_FAST = 8'h0B;

    // register index, taken from address bits 3:2
    localparam logic [1:0] RIDX_CFG  = 2'd0;
    localparam logic [1:0] RIDX_SWC  = 2'd1;
    localparam logic [1:0] RIDX_SWD  = 2'd2;
    localparam logic [1:0] RIDX_STAT = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_SHIFT = 2'd2,
        SQ_GUARD = 2'd3
    } seq_state_t;

endpackage

// File: rtl/smem_tickgen.sv
// Module: serial clock tick generator.
// While enabled, emits a one-cycle tick every PRESC+1 system clocks; each tick
// is one serial half period. The counter restarts from zero whenever the
// enable drops, so the first tick always comes PRESC+1 clocks after enabling.
module smem_tickgen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);

    logic [PRESC_W-1:0] cnt_q;

    // tick whenever the running count reaches the prescaler value
    assign tick = en && (cnt_q == presc);

    // divider counter, cleared while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == presc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/smem_shifter.sv
// Module: one-byte serial shift engine, mode 0.
// A start pulse loads a byte and puts its top bit on the data-out line with the
// clock low. Each following tick alternates a rising edge (sample input) and a
// falling edge (advance output). After 16 ticks the byte is done, the clock is
// low, and the received byte is available. Assumes start is only given when idle.
module smem_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);

    logic [7:0] tx_q;
    logic [7:0] rx_q;
    logic [3:0] edge_cnt;
    logic       busy_q;
    logic       done_q;
    logic       sclk_q;

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = tx_q[7];

    // bit sequencing: rising edges sample, falling edges shift out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rx_q     <= '0;
            edge_cnt <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            sclk_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                tx_q     <= tx_byte;
                edge_cnt <= '0;
                busy_q   <= 1'b1;
                sclk_q   <= 1'b0;
            end else if (busy_q && tick) begin
                if (!edge_cnt[0]) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[6:0], 1'b0};
                    if (edge_cnt == 4'd15) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smem_regs.sv
// Module: control and status registers.
// Holds the prescaler, per-bank two-byte-address and fast-read bits, the last
// software command written (for readback) and the sticky transfer-done bit.
// The software data register lives in the sequencer; its value comes in here
// only for the read mux. Writes are single-cycle strobes from the sequencer.
module smem_regs #(
    parameter int NUM_BANKS = 4,
    parameter int PRESC_W   = 8,
    parameter int PRESC_RST = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               sel,
    input  logic [smem_pkg::DW-1:0]  wdata,
    input  logic [smem_pkg::DW-1:0]  sw_data,
    input  logic                     done_set,
    output logic [PRESC_W-1:0]       presc,
    output logic [NUM_BANKS-1:0]     two_byte,
    output logic [NUM_BANKS-1:0]     fast,
    output logic                     done,
    output logic                     done_clr,
    output logic [smem_pkg::DW-1:0]  rd_val
);
    import smem_pkg::*;

    localparam int CFG_W = PRESC_W + 2 * NUM_BANKS;
    localparam int SWC_W = 13;

    logic [PRESC_W-1:0]   presc_q;
    logic [NUM_BANKS-1:0] twob_q;
    logic [NUM_BANKS-1:0] fast_q;
    logic [SWC_W-1:0]     swc_q;
    logic                 done_q;

    assign presc    = presc_q;
    assign two_byte = twob_q;
    assign fast     = fast_q;
    assign done     = done_q;
    assign done_clr = wr_en && (sel == RIDX_STAT) && wdata[0];

    // configuration and command readback registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= PRESC_W'(PRESC_RST);
            twob_q  <= '0;
            fast_q  <= '0;
            swc_q   <= '0;
        end else if (wr_en) begin
            if (sel == RIDX_CFG) begin
                presc_q <= wdata[PRESC_W-1:0];
                twob_q  <= wdata[PRESC_W +: NUM_BANKS];
                fast_q  <= wdata[PRESC_W+NUM_BANKS +: NUM_BANKS];
            end
            if (sel == RIDX_SWC) begin
                swc_q <= wdata[SWC_W-1:0];
            end
        end
    end

    // sticky done bit: set by the sequencer, cleared by a write of one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_set) begin
            done_q <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    // register read mux
    always_comb begin
        rd_val = '0;
        case (sel)
            RIDX_CFG:  rd_val[CFG_W-1:0] = {fast_q, twob_q, presc_q};
            RIDX_SWC:  rd_val[SWC_W-1:0] = swc_q;
            RIDX_SWD:  rd_val            = sw_data;
            default:   rd_val[0]         = done_q;
        endcase
    end

endmodule

// File: rtl/smem_ctrl.sv
// Module: memory-mapped serial memory controller (top).
// Decodes bus requests into register accesses, memory reads and software
// transfers. A memory read or software transfer is run as a list of bytes
// indexed by a counter; the byte to send is computed from the index (command,
// address bytes, dummy, data lanes). After the last byte the chip select is
// released and held high for one serial period before completion.
// Assumes the master holds bus_req until it sees the one-cycle bus_ready.
module smem_ctrl #(
    parameter int NUM_BANKS  = 4,
    parameter int BUS_AW     = 32,
    parameter int DEV_ADDR_W = 24,
    parameter int PRESC_W    = 8,
    parameter int PRESC_RST  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_write,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [smem_pkg::DW-1:0] bus_wdata,
    output logic [smem_pkg::DW-1:0] bus_rdata,
    output logic                    bus_ready,
    output logic                    spi_sclk,
    output logic                    spi_mosi,
    input  logic                    spi_miso,
    output logic [NUM_BANKS-1:0]    spi_cs_n,
    output logic                    irq
);
    import smem_pkg::*;

    localparam int BSEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int SWC_BANK_L = 8;
    localparam int SWC_CNT_L  = SWC_BANK_L + BSEL_W;
    localparam int MAX_SW_CNT = 4;

    seq_state_t            st_q;
    logic                  j_sw;
    logic [BSEL_W-1:0]     j_bank;
    logic [7:0]            j_cmd;
    logic [DEV_ADDR_W-1:0] j_addr;
    logic [1:0]            j_alen;
    logic [3:0]            j_hdr;
    logic [3:0]            j_total;
    logic [3:0]            idx_q;
    logic                  g_cnt_q;
    logic [DW-1:0]         dreg_q;
    logic [DW-1:0]         rdata_q;
    logic                  ready_q;
    logic                  rd_ack_q;
    logic [NUM_BANKS-1:0]  cs_q;

    logic [PRESC_W-1:0]    cfg_presc;
    logic [NUM_BANKS-1:0]  cfg_twob;
    logic [NUM_BANKS-1:0]  cfg_fast;
    logic                  sts_done;
    logic                  done_clr;
    logic [DW-1:0]         reg_rd;

    logic                  accept;
    logic                  reg_space;
    logic                  reg_wr;
    logic                  done_set;
    logic                  tick;
    logic                  tick_en;
    logic                  sh_start;
    logic                  sh_busy;
    logic                  sh_done;
    logic [7:0]            sh_rx;
    logic [7:0]            tx_byte;
    logic [1:0]            lane;
    logic [1:0]            asel;
    logic [BSEL_W-1:0]     rd_bank;
    logic [BSEL_W-1:0]     sw_bank;
    logic [2:0]            sw_cnt;
    logic [2:0]            rd_nbytes;
    logic [1:0]            rd_alen;

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;
    assign spi_cs_n  = cs_q;
    assign irq       = sts_done;

    // request decode: accepted only when idle and not in the ack cycle
    assign accept    = (st_q == SQ_IDLE) && bus_req && !ready_q;
    assign reg_space = bus_addr[BUS_AW-1];
    assign reg_wr    = accept && reg_space && bus_write;
    assign done_set  = (st_q == SQ_GUARD) && tick && g_cnt_q && j_sw;
    assign tick_en   = sh_busy || (st_q == SQ_GUARD);
    assign sh_start  = (st_q == SQ_LOAD);

    // request field extraction for new jobs
    always_comb begin
        rd_bank   = bus_addr[DEV_ADDR_W +: BSEL_W];
        sw_bank   = bus_wdata[SWC_BANK_L +: BSEL_W];
        sw_cnt    = (bus_wdata[SWC_CNT_L +: 3] > 3'(MAX_SW_CNT)) ?
                    3'(MAX_SW_CNT) : bus_wdata[SWC_CNT_L +: 3];
        rd_alen   = cfg_twob[rd_bank] ? 2'd2 : 2'd3;
        case (bus_size)
            2'd0:    rd_nbytes = 3'd1;
            2'd1:    rd_nbytes = 3'd2;
            default: rd_nbytes = 3'd4;
        endcase
    end

    // outgoing byte for the current index
    always_comb begin
        lane = 2'(idx_q - j_hdr);
        asel = j_alen - idx_q[1:0];
        if (idx_q == 4'd0) begin
            tx_byte = j_cmd;
        end else if (idx_q <= {2'b00, j_alen}) begin
            tx_byte = j_addr[8*asel +: 8];
        end else if (idx_q < j_hdr) begin
            tx_byte = 8'h00;
        end else begin
            tx_byte = dreg_q[8*lane +: 8];
        end
    end

    // job sequencer: start, byte stepping, release gap and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            j_sw     <= 1'b0;
            j_bank   <= '0;
            j_cmd    <= '0;
            j_addr   <= '0;
            j_alen   <= '0;
            j_hdr    <= '0;
            j_total  <= '0;
            idx_q    <= '0;
            g_cnt_q  <= 1'b0;
            dreg_q   <= '0;
            rdata_q  <= '0;
            ready_q  <= 1'b0;
            rd_ack_q <= 1'b0;
            cs_q     <= '1;
        end else begin
            ready_q  <= 1'b0;
            rd_ack_q <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    if (accept && reg_space) begin
                        ready_q <= 1'b1;
                        rdata_q <= reg_rd;
                        if (bus_write && bus_addr[3:2] == RIDX_SWD) begin
                            dreg_q <= bus_wdata;
                        end
                        if (bus_write && bus_addr[3:2] == RIDX_SWC) begin
                            j_sw    <= 1'b1;
                            j_bank  <= sw_bank;
                            j_cmd   <= bus_wdata[7:0];
                            j_alen  <= 2'd0;
                            j_hdr   <= 4'd1;
                            j_total <= 4'd1 + {1'b0, sw_cnt};
                            idx_q   <= '0;
                            cs_q    <= ~(NUM_BANKS'(1) << sw_bank);
                            st_q    <= SQ_LOAD;
                        end
                    end else if (accept && bus_write) begin
                        ready_q <= 1'b1;
                    end else if (accept) begin
                        j_sw    <= 1'b0;
                        j_bank  <= rd_bank;
                        j_cmd   <= cfg_fast[rd_bank] ? OP_FAST : OP_READ;
                        j_addr  <= bus_addr[DEV_ADDR_W-1:0];
                        j_alen  <= rd_alen;
                        j_hdr   <= 4'd1 + {2'b00, rd_alen} + {3'b000, cfg_fast[rd_bank]};
                        j_total <= 4'd1 + {2'b00, rd_alen} + {3'b000, cfg_fast[rd_bank]}
                                   + {1'b0, rd_nbytes};
                        idx_q   <= '0;
                        dreg_q  <= '0;
                        cs_q    <= ~(NUM_BANKS'(1) << rd_bank);
                        st_q    <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    st_q <= SQ_SHIFT;
                end
                SQ_SHIFT: begin
                    if (sh_done) begin
                        if (idx_q >= j_hdr) begin
                            dreg_q[8*lane +: 8] <= sh_rx;
                        end
                        if (idx_q == j_total - 4'd1) begin
                            cs_q    <= '1;
                            g_cnt_q <= 1'b0;
                            st_q    <= SQ_GUARD;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= SQ_LOAD;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (g_cnt_q) begin
                            st_q <= SQ_IDLE;
                            if (!j_sw) begin
                                ready_q  <= 1'b1;
                                rd_ack_q <= 1'b1;
                                rdata_q  <= dreg_q;
                            end
                        end else begin
                            g_cnt_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    smem_regs #(
        .NUM_BANKS (NUM_BANKS),
        .PRESC_W   (PRESC_W),
        .PRESC_RST (PRESC_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (bus_addr[3:2]),
        .wdata    (bus_wdata),
        .sw_data  (dreg_q),
        .done_set (done_set),
        .presc    (cfg_presc),
        .two_byte (cfg_twob),
        .fast     (cfg_fast),
        .done     (sts_done),
        .done_clr (done_clr),
        .rd_val   (reg_rd)
    );

    smem_tickgen #(
        .PRESC_W (PRESC_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .presc (cfg_presc),
        .tick  (tick)
    );

    smem_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

endmodule

// File: rtl/smem_chk.sv
// Module: protocol checker for smem_ctrl, attached with bind.
// Assumes it sees the top ports plus the prescaler, the memory-read ack flag
// and the status clear strobe from inside the top.
module smem_chk #(
    parameter int NUM_BANKS = 4,
    parameter int PRESC_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] spi_cs_n,
    input logic                 spi_sclk,
    input logic                 spi_mosi,
    input logic                 bus_ready,
    input logic                 irq,
    input logic [PRESC_W-1:0]   presc,
    input logic                 rd_ack,
    input logic                 clr_stb
);

    logic [15:0] gap_q;

    // cycles since every chip select went high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !(&spi_cs_n)) begin
            gap_q <= '0;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1);

    a_r7_clock_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sclk);

    a_r7_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    a_r9_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && rd_ack) |-> (32'(gap_q) >= 2 * (32'(presc) + 1)));

    a_r11_irq_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_stb));

endmodule

bind smem_ctrl smem_chk #(
    .NUM_BANKS (NUM_BANKS),
    .PRESC_W   (PRESC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .bus_ready (bus_ready),
    .irq       (irq),
    .presc     (cfg_presc),
    .rd_ack    (rd_ack_q),
    .clr_stb   (done_clr)
);

// File: tb/tb_smem_ctrl.sv
// Bench: directed corners plus seeded random reads against a serial device model.
module tb_smem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_cs_n;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    smem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // ---------------- serial device model ----------------
    wire        cs_all = &spi_cs_n;
    logic [7:0] lg [0:15];
    int         lgn;
    int         bitc;
    int         nrise;
    int         ncs_fall = 0;
    int         mdl_alen = 3;
    logic [7:0] inb;
    logic [7:0] outb;
    logic [7:0] mcmd;
    logic [23:0] maddr;
    logic [3:0] cs_seen;
    time        t_r1, t_r2, t_csrise;

    function automatic logic [7:0] mdata(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [23:0] amask(input int alen);
        return (alen == 2) ? 24'h00FFFF : 24'hFFFFFF;
    endfunction

    function automatic logic [7:0] resp(input int b);
        int ds;
        if (mcmd == 8'h03 || mcmd == 8'h0B) begin
            ds = (mcmd == 8'h0B) ? mdl_alen + 2 : mdl_alen + 1;
            if (b >= ds) return mdata((maddr + 24'(b - ds)) & amask(mdl_alen));
            return 8'h00;
        end
        return 8'hC0 + 8'(b);
    endfunction

    always @(negedge cs_all) begin
        lgn = 0; bitc = 0; nrise = 0; outb = 8'h00; spi_miso = 1'b0;
        mcmd = 8'h00; maddr = '0; ncs_fall++;
    end

    always @(posedge cs_all) t_csrise = $time;

    always @(posedge spi_sclk) begin
        if (!cs_all) begin
            nrise++;
            if (nrise == 1) begin t_r1 = $time; cs_seen = spi_cs_n; end
            if (nrise == 2) t_r2 = $time;
            inb = {inb[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                if (lgn < 16) lg[lgn] = inb;
                if (lgn == 0) mcmd = inb;
                else if (lgn <= mdl_alen && (mcmd == 8'h03 || mcmd == 8'h0B))
                    maddr = {maddr[15:0], inb};
                lgn++;
                bitc = 0;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!cs_all) begin
            if (bitc == 0) outb = resp(lgn);
            else outb = {outb[6:0], 1'b0};
            spi_miso = outb[7];
        end
    end

    // ---------------- bench helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                            input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] exp_rdata(input logic [23:0] a, input int sz, input int alen);
        logic [31:0] r = '0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < n; k++)
            r[8*k +: 8] = mdata((a + 24'(k)) & amask(alen));
        return r;
    endfunction

    logic [31:0] cfg_cur;

    task automatic set_cfg(input logic [31:0] v);
        logic [31:0] d;
        bus_xfer(1'b1, 32'h8000_0000, 2'd2, v, d);
        cfg_cur = v;
    endtask

    // one memory read, checked for header bytes, data lanes, select and gap
    task automatic mem_rd(input int bank, input logic [23:0] a, input int sz,
                          input string tag);
        logic [31:0] d, e;
        logic [7:0]  eh [0:8];
        int alen, fast, hdr, n, total, presc;
        bit ok;
        alen  = cfg_cur[8 + bank] ? 2 : 3;
        fast  = cfg_cur[12 + bank] ? 1 : 0;
        presc = int'(cfg_cur[7:0]);
        n     = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        hdr   = 1 + alen + fast;
        total = hdr + n;
        mdl_alen = alen;
        eh[0] = fast ? 8'h0B : 8'h03;
        for (int i = 1; i <= alen; i++) eh[i] = a[8*(alen - i) +: 8];
        for (int i = alen + 1; i < 9; i++) eh[i] = 8'h00;
        bus_xfer(1'b0, {6'd0, 2'(bank), a}, 2'(sz), 32'd0, d);
        ok = (lgn == total);
        for (int i = 0; i < total && i < 16; i++)
            if (lg[i] != ((i < 9) ? eh[i] : 8'h00)) ok = 1'b0;
        chk(ok, {tag, " R3 R4 R5 header bytes"}, {lg[0], lg[1], lg[2], 8'(lgn)},
            {eh[0], eh[1], eh[2], 8'(total)});
        e = exp_rdata(a & amask(alen), sz, alen);
        chk(d == e, {tag, " R6 data lanes"}, d, e);
        chk(cs_seen == ~(4'b1 << bank), {tag, " R2 chip select"}, 32'(cs_seen),
            32'(~(4'b1 << bank)));
        chk(($time - t_csrise) >= 64'(2 * (presc + 1) * 10), {tag, " R9 release gap"},
            32'(($time - t_csrise) / 10), 32'(2 * (presc + 1)));
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] d;
        int f0;
        void'($urandom(32'h5EED_0042));
        cfg_cur = 32'h3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 4'hF && !spi_sclk && !irq && !bus_ready, "R1 reset outputs",
            {26'd0, spi_cs_n, spi_sclk, irq}, 32'h3C);
        bus_xfer(1'b0, 32'h8000_0000, 2'd2, 32'd0, d);
        chk(d == 32'h3, "R1 config reset value", d, 32'h3);

        // directed: standard three-byte word read on bank 0 at reset config
        mem_rd(0, 24'h123456, 2, "std3");
        chk((t_r2 - t_r1) == 64'(2 * 4 * 10), "R8 period presc 3",
            32'((t_r2 - t_r1) / 10), 32'd8);

        // prescaler 0: half the system clock
        set_cfg(32'h0000_0000);
        mem_rd(3, 24'hFEDCBA, 0, "p0");
        chk((t_r2 - t_r1) == 64'(20), "R8 period presc 0", 32'((t_r2 - t_r1) / 10), 32'd2);

        // two-byte address on bank 1, halfword
        set_cfg(32'h0000_0205);
        mem_rd(1, 24'h77ABCD, 1, "twob");
        chk((t_r2 - t_r1) == 64'(2 * 6 * 10), "R8 period presc 5",
            32'((t_r2 - t_r1) / 10), 32'd12);

        // fast read on bank 2, byte, and fast plus two-byte on bank 2, word
        set_cfg(32'h0000_4001);
        mem_rd(2, 24'h0A0B0C, 0, "fast");
        set_cfg(32'h0000_4401);
        mem_rd(2, 24'h00FFFE, 3, "fast2b");

        // memory-space write: acknowledged, no serial activity
        f0 = ncs_fall;
        bus_xfer(1'b1, 32'h0100_0000, 2'd2, 32'hDEADBEEF, d);
        repeat (20) @(negedge clk);
        chk(ncs_fall == f0 && spi_cs_n == 4'hF, "R12 write ignored", 32'(ncs_fall - f0), 32'd0);

        // software transfer: cmd 0x05, bank 2, three bytes
        bus_xfer(1'b1, 32'h8000_0008, 2'd2, 32'h4433_2211, d);
        bus_xfer(1'b1, 32'h8000_0004, 2'd2, 32'h0000_0E05, d);
        bus_xfer(1'b0, 32'h8000_000C, 2'd2, 32'd0, d);
        chk(spi_cs_n == 4'hF && d[0] == 1'b1, "R13 stalled until done",
            {spi_cs_n, 27'd0, d[0]}, 32'hF000_0001);
        chk(lgn == 4 && lg[0] == 8'h05 && lg[1] == 8'h11 && lg[2] == 8'h22 && lg[3] == 8'h33,
            "R10 bytes sent", {lg[0], lg[1], lg[2], lg[3]}, 32'h0511_2233);
        chk(cs_seen == 4'b1011, "R10 bank select", 32'(cs_seen), 32'hB);
        bus_xfer(1'b0, 32'h8000_0008, 2'd2, 32'd0, d);
        chk(d == 32'h44C3_C2C1, "R10 received write-back", d, 32'h44C3_C2C1);
        chk(irq == 1'b1, "R11 irq set", 32'(irq), 32'd1);
        bus_xfer(1'b1, 32'h8000_000C, 2'd2, 32'h0000_0000, d);
        @(negedge clk);
        chk(irq == 1'b1, "R11 write zero keeps irq", 32'(irq), 32'd1);
        bus_xfer(1'b1, 32'h8000_000C, 2'd2, 32'h0000_0001, d);
        @(negedge clk);
        chk(irq == 1'b0, "R11 write one clears irq", 32'(irq), 32'd0);

        // software transfer count above four is limited to four
        bus_xfer(1'b1, 32'h8000_0004, 2'd2, 32'h0000_1C06, d);
        bus_xfer(1'b0, 32'h8000_000C, 2'd2, 32'd0, d);
        chk(lgn == 5 && lg[0] == 8'h06, "R10 count clamp", 32'(lgn), 32'd5);
        bus_xfer(1'b1, 32'h8000_000C, 2'd2, 32'h1, d);

        // seeded random reads over configurations
        for (int it = 0; it < 30; it++) begin
            logic [31:0] cv;
            cv = {16'd0, 4'($urandom), 4'($urandom), 8'($urandom % 4)};
            set_cfg(cv);
            mem_rd(int'($urandom % 4), 24'($urandom), int'($urandom % 4), "rnd");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule